// File: doc/BRIEF.md
# Sliding Two-Dimensional Pixel Window Register

This block holds a band of image pixels in a two-dimensional register array, 16 rows by 32 columns of 8-bit pixels, and slides the whole band one column to the left on command. Each slide drops the leftmost column of every row and fills the rightmost column from a 16-entry edge vector, one entry per row. The band therefore moves across an image line without any pixel being fetched a second time. Any single row can also be written in full from a wide load port.

Several stencil windows are taken from the band at fixed column offsets and are offered in parallel to a wide compute datapath. Each window is 16 columns wide and spans all rows. Every window is available as a full 2D tile, as one selected row (horizontal 1D form) and as one selected column (vertical 1D form). A second, non-shifting register array of 16 rows by 16 columns holds the stencil operand, such as filter coefficients or a current-frame block. It is written one row at a time and is read out in the same three forms.

All outputs are combinational reads of the registered state. A load, a shift or an operand write becomes visible in the cycle after it is applied.

Top module: `stencil_window_top`

## Requirements
- R1: After reset is released, every band pixel and every operand pixel reads as 0 on all outputs.
- R2: With load_en high, all 32 pixels of the band row given by load_row take load_data at the next rising edge (pixel c at bits [8c+7:8c]). No other row is changed by the load.
- R3: With shift_en high, every band row not being loaded moves left by one column at the next edge. Column j takes the old value of column j+1, and the old column 0 is discarded.
- R4: On a shift, column 31 of row r takes edge_col bits [8r+7:8r].
- R5: When load_en and shift_en are both high, the row addressed by load_row takes load_data and does not shift. All other rows shift.
- R6: With load_en and shift_en both low, the band holds its contents.
- R7: With coef_we high, operand row coef_row takes all 16 pixels of coef_data at the next edge. The operand array never moves on shift_en, and it holds when coef_we is low.
- R8: win_2d carries NUM_WIN windows. Window w covers band columns 4w to 4w+15 of all rows. Pixel (row r, window column k) of window w sits at bit offset ((w*16+r)*16+k)*8.
- R9: win_h gives band row row_sel of each window, with window w column k at offset (w*16+k)*8. coef_h gives operand row row_sel, with column k at offset k*8.
- R10: win_v gives window column col_sel of each window across all rows, with window w row r at offset (w*16+r)*8. coef_v gives operand column col_sel, with row r at offset r*8. coef_2d places operand pixel (r,k) at offset (r*16+k)*8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write one full band row |
| load_row | input | 4 | Band row to write |
| load_data | input | 256 | 32 pixels for the band row |
| shift_en | input | 1 | Slide the band left by one column |
| edge_col | input | 128 | New rightmost pixel for each row |
| coef_we | input | 1 | Write one operand row |
| coef_row | input | 4 | Operand row to write |
| coef_data | input | 128 | 16 pixels for the operand row |
| row_sel | input | 4 | Row picked for the horizontal forms |
| col_sel | input | 4 | Window column picked for the vertical forms |
| win_2d | output | 10240 | All windows as 2D tiles |
| win_h | output | 640 | Selected row of each window |
| win_v | output | 640 | Selected column of each window |
| coef_2d | output | 2048 | Whole operand array |
| coef_h | output | 128 | Selected operand row |
| coef_v | output | 128 | Selected operand column |

## Verification
A load, a shift or an operand write passes through exactly one register, so its result is due at the first rising edge after the inputs are applied. The select inputs reach the 1D forms with no register between them. The driver applies each stimulus and its selects at a falling edge and queues the expected outputs at the same moment. The monitor pops that entry after the next rising edge and compares all six outputs 2 ns later, so every comparison falls in exactly the cycle its result is due.

// File: rtl/sw_pkg.sv
package sw_pkg;
  parameter int SW_ROWS     = 16;
  parameter int SW_COLS     = 32;
  parameter int SW_PIX_W    = 8;
  parameter int SW_WIN_COLS = 16;
  parameter int SW_NUM_WIN  = 5;
  parameter int SW_WIN_STEP = 4;
endpackage

// File: rtl/sw_shift_row.sv
module sw_shift_row #(
  parameter int COLS  = sw_pkg::SW_COLS,
  parameter int PIX_W = sw_pkg::SW_PIX_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load_hit,
  input  logic                            shift_en,
  input  logic [COLS-1:0][PIX_W-1:0]      load_data,
  input  logic [PIX_W-1:0]                edge_pix,
  output logic [COLS-1:0][PIX_W-1:0]      row_q
);
  function automatic logic [COLS-1:0][PIX_W-1:0] slide_left(
      input logic [COLS-1:0][PIX_W-1:0] cur, input logic [PIX_W-1:0] fill);
    logic [COLS-1:0][PIX_W-1:0] nxt;
    for (int j = 0; j < COLS - 1; j++) nxt[j] = cur[j+1];
    nxt[COLS-1] = fill;
    return nxt;
  endfunction

  logic do_load, do_shift, do_hold;
  assign do_load  = load_hit;
  assign do_shift = shift_en && !load_hit;
  assign do_hold  = !load_hit && !shift_en;

  always_ff @(posedge clk) begin
    if (!rst_n)        row_q <= '0;
    else if (do_load)  row_q <= load_data;
    else if (do_shift) row_q <= slide_left(row_q, edge_pix);
  end

  // R2 R5
  row_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> row_q == $past(load_data));
  // R3
  shift_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_shift |=> row_q[0] == $past(row_q[1]));
  // R4
  edge_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_shift |=> row_q[COLS-1] == $past(edge_pix));
  // R6
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_hold |=> $stable(row_q));
endmodule

// File: rtl/sw_coef_array.sv
module sw_coef_array #(
  parameter int ROWS  = sw_pkg::SW_ROWS,
  parameter int CCOLS = sw_pkg::SW_WIN_COLS,
  parameter int PIX_W = sw_pkg::SW_PIX_W,
  localparam int RW   = $clog2(ROWS)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 coef_we,
  input  logic [RW-1:0]                        coef_row,
  input  logic [CCOLS-1:0][PIX_W-1:0]          coef_data,
  output logic [ROWS-1:0][CCOLS-1:0][PIX_W-1:0] coef_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       coef_q <= '0;
    else if (coef_we) coef_q[coef_row] <= coef_data;
  end

  // R7
  coef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |=> coef_q[$past(coef_row)] == $past(coef_data));
  // R7
  coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !coef_we |=> $stable(coef_q));
endmodule

// File: rtl/sw_window_tap.sv
module sw_window_tap #(
  parameter int ROWS     = sw_pkg::SW_ROWS,
  parameter int WIN_COLS = sw_pkg::SW_WIN_COLS,
  parameter int PIX_W    = sw_pkg::SW_PIX_W,
  localparam int RW      = $clog2(ROWS),
  localparam int CW      = $clog2(WIN_COLS)
) (
  input  logic [ROWS-1:0][WIN_COLS-1:0][PIX_W-1:0] tile_in,
  input  logic [RW-1:0]                            row_sel,
  input  logic [CW-1:0]                            col_sel,
  output logic [ROWS-1:0][WIN_COLS-1:0][PIX_W-1:0] tile_2d,
  output logic [WIN_COLS-1:0][PIX_W-1:0]           tile_h,
  output logic [ROWS-1:0][PIX_W-1:0]               tile_v
);
  assign tile_2d = tile_in;
  assign tile_h  = tile_in[row_sel];

  always_comb begin
    for (int r = 0; r < ROWS; r++) tile_v[r] = tile_in[r][col_sel];
  end
endmodule

// File: rtl/stencil_window_top.sv
module stencil_window_top #(
  parameter int ROWS     = sw_pkg::SW_ROWS,
  parameter int COLS     = sw_pkg::SW_COLS,
  parameter int PIX_W    = sw_pkg::SW_PIX_W,
  parameter int WIN_COLS = sw_pkg::SW_WIN_COLS,
  parameter int NUM_WIN  = sw_pkg::SW_NUM_WIN,
  parameter int WIN_STEP = sw_pkg::SW_WIN_STEP,
  localparam int RW      = $clog2(ROWS),
  localparam int CW      = $clog2(WIN_COLS),
  localparam int TILE_W  = ROWS * WIN_COLS * PIX_W,
  localparam int HROW_W  = WIN_COLS * PIX_W,
  localparam int VCOL_W  = ROWS * PIX_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_en,
  input  logic [RW-1:0]              load_row,
  input  logic [COLS*PIX_W-1:0]      load_data,
  input  logic                       shift_en,
  input  logic [ROWS*PIX_W-1:0]      edge_col,
  input  logic                       coef_we,
  input  logic [RW-1:0]              coef_row,
  input  logic [WIN_COLS*PIX_W-1:0]  coef_data,
  input  logic [RW-1:0]              row_sel,
  input  logic [CW-1:0]              col_sel,
  output logic [NUM_WIN*TILE_W-1:0]  win_2d,
  output logic [NUM_WIN*HROW_W-1:0]  win_h,
  output logic [NUM_WIN*VCOL_W-1:0]  win_v,
  output logic [TILE_W-1:0]          coef_2d,
  output logic [HROW_W-1:0]          coef_h,
  output logic [VCOL_W-1:0]          coef_v
);
  logic [ROWS-1:0][COLS-1:0][PIX_W-1:0]     band;
  logic [ROWS-1:0][WIN_COLS-1:0][PIX_W-1:0] coef_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic load_hit;
    assign load_hit = load_en && (load_row == RW'(r));
    sw_shift_row #(.COLS(COLS), .PIX_W(PIX_W)) u_row (
      .clk(clk), .rst_n(rst_n), .load_hit(load_hit), .shift_en(shift_en),
      .load_data(load_data), .edge_pix(edge_col[r*PIX_W +: PIX_W]),
      .row_q(band[r]));
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int OFF = w * WIN_STEP;
    logic [ROWS-1:0][WIN_COLS-1:0][PIX_W-1:0] tile_in, tile_2d;
    logic [WIN_COLS-1:0][PIX_W-1:0]           tile_h;
    logic [ROWS-1:0][PIX_W-1:0]               tile_v;
    for (genvar r = 0; r < ROWS; r++) begin : g_slice
      assign tile_in[r] = band[r][OFF +: WIN_COLS];
    end
    sw_window_tap #(.ROWS(ROWS), .WIN_COLS(WIN_COLS), .PIX_W(PIX_W)) u_tap (
      .tile_in(tile_in), .row_sel(row_sel), .col_sel(col_sel),
      .tile_2d(tile_2d), .tile_h(tile_h), .tile_v(tile_v));
    assign win_2d[w*TILE_W +: TILE_W] = tile_2d;
    assign win_h[w*HROW_W +: HROW_W]  = tile_h;
    assign win_v[w*VCOL_W +: VCOL_W]  = tile_v;
  end

  sw_coef_array #(.ROWS(ROWS), .CCOLS(WIN_COLS), .PIX_W(PIX_W)) u_coef (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_row(coef_row),
    .coef_data(coef_data), .coef_q(coef_q));

  assign coef_2d = coef_q;
  assign coef_h  = coef_q[row_sel];
  always_comb begin
    for (int r = 0; r < ROWS; r++) coef_v[r*PIX_W +: PIX_W] = coef_q[r][col_sel];
  end

  initial begin
    fit_chk: assert ((NUM_WIN - 1) * WIN_STEP + WIN_COLS <= COLS);
  end
endmodule

// File: tb/stencil_window_top_bench.sv
module stencil_window_top_bench;
  localparam int ROWS = 16, COLS = 32, PW = 8, WC = 16, NW = 5, STEP = 4;
  localparam int TILE = ROWS * WC * PW;

  logic clk = 0;
  logic rst_n = 0;
  logic load_en = 0, shift_en = 0, coef_we = 0;
  logic [3:0] load_row = 0, coef_row = 0, row_sel = 0, col_sel = 0;
  logic [COLS*PW-1:0] load_data = '0;
  logic [ROWS*PW-1:0] edge_col = '0;
  logic [WC*PW-1:0]   coef_data = '0;
  logic [NW*TILE-1:0]    win_2d;
  logic [NW*WC*PW-1:0]   win_h;
  logic [NW*ROWS*PW-1:0] win_v;
  logic [TILE-1:0]       coef_2d;
  logic [WC*PW-1:0]      coef_h;
  logic [ROWS*PW-1:0]    coef_v;

  always #4 clk = ~clk;

  stencil_window_top u_stencil_window_top (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_row(load_row),
    .load_data(load_data), .shift_en(shift_en), .edge_col(edge_col),
    .coef_we(coef_we), .coef_row(coef_row), .coef_data(coef_data),
    .row_sel(row_sel), .col_sel(col_sel), .win_2d(win_2d), .win_h(win_h),
    .win_v(win_v), .coef_2d(coef_2d), .coef_h(coef_h), .coef_v(coef_v));

  typedef struct {
    logic [NW*TILE-1:0]    e2d;
    logic [NW*WC*PW-1:0]   eh;
    logic [NW*ROWS*PW-1:0] ev;
    logic [TILE-1:0]       c2d;
    logic [WC*PW-1:0]      ch;
    logic [ROWS*PW-1:0]    cv;
    string                 tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] bm [ROWS][COLS];
  logic [7:0] cm [ROWS][WC];
  int checks = 0, failures = 0;
  bit finished = 0;

  function automatic logic [7:0] pv(int r, int c, int seed);
    return 8'((r * 37 + c * 5 + seed * 11) & 255);
  endfunction

  task automatic check_vec(string what, string tag, logic [NW*TILE-1:0] act,
                           logic [NW*TILE-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t build(string tag);
    exp_t e;
    e.e2d = '0; e.eh = '0; e.ev = '0; e.c2d = '0; e.ch = '0; e.cv = '0;
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < ROWS; r++)
        for (int k = 0; k < WC; k++)
          e.e2d[((w*ROWS + r)*WC + k)*PW +: PW] = bm[r][w*STEP + k];
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < WC; k++)
        e.eh[(w*WC + k)*PW +: PW] = bm[row_sel][w*STEP + k];
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < ROWS; r++)
        e.ev[(w*ROWS + r)*PW +: PW] = bm[r][w*STEP + int'(col_sel)];
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < WC; k++)
        e.c2d[(r*WC + k)*PW +: PW] = cm[r][k];
    for (int k = 0; k < WC; k++) e.ch[k*PW +: PW] = cm[row_sel][k];
    for (int r = 0; r < ROWS; r++) e.cv[r*PW +: PW] = cm[r][col_sel];
    e.tag = tag;
    return e;
  endfunction

  // Driver: applies one cycle of stimulus at a falling edge, updates the model, queues the expectation.
  task automatic do_op(bit ld, int lrow, int lseed, bit sh, int eseed,
                       bit cw, int crow, int cseed, int rs, int cs, string tag);
    logic [7:0] nb [ROWS][COLS];
    @(negedge clk);
    load_en = ld; load_row = 4'(lrow); shift_en = sh; coef_we = cw;
    coef_row = 4'(crow); row_sel = 4'(rs); col_sel = 4'(cs);
    for (int c = 0; c < COLS; c++) load_data[c*PW +: PW] = pv(lrow, c, lseed);
    for (int r = 0; r < ROWS; r++) edge_col[r*PW +: PW] = pv(r, 99, eseed);
    for (int k = 0; k < WC; k++) coef_data[k*PW +: PW] = pv(crow, k + 50, cseed);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        if (ld && r == lrow)  nb[r][c] = pv(lrow, c, lseed);
        else if (sh)          nb[r][c] = (c == COLS-1) ? pv(r, 99, eseed) : bm[r][c+1];
        else                  nb[r][c] = bm[r][c];
      end
    bm = nb;
    if (cw) for (int k = 0; k < WC; k++) cm[crow][k] = pv(crow, k + 50, cseed);
    sb.push_back(build(tag));
  endtask

  // Monitor: each queued item is due at the first rising edge after it was driven.
  initial begin
    exp_t it;
    forever begin
      wait (sb.size() > 0);
      @(posedge clk);
      #2;
      it = sb.pop_front();
      check_vec("win_2d", it.tag, win_2d, it.e2d);
      check_vec("win_h", it.tag, {'0, win_h}, {'0, it.eh});
      check_vec("win_v", it.tag, {'0, win_v}, {'0, it.ev});
      check_vec("coef_2d", it.tag, {'0, coef_2d}, {'0, it.c2d});
      check_vec("coef_h", it.tag, {'0, coef_h}, {'0, it.ch});
      check_vec("coef_v", it.tag, {'0, coef_v}, {'0, it.cv});
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) bm[r][c] = 8'h00;
      for (int k = 0; k < WC; k++) cm[r][k] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: everything reads zero after reset
    do_op(0, 0, 0, 0, 0, 0, 0, 0, 3, 7, "R1");
    // R2: fill every band row, one per cycle
    for (int r = 0; r < ROWS; r++) do_op(1, r, 1, 0, 0, 0, 0, 0, r, r, "R2/R8");
    // R7: fill every operand row
    for (int r = 0; r < ROWS; r++) do_op(0, 0, 0, 0, 0, 1, r, 2, 15 - r, r, "R7/R10");
    // R3 R4: a few shifts with varied selects; operand must not move (R7)
    for (int i = 0; i < 5; i++) do_op(0, 0, 0, 1, i + 3, 0, 0, 0, i * 3, 15 - i, "R3/R4/R7/R9/R10");
    // R5: load and shift in the same cycle, row 5
    do_op(1, 5, 7, 1, 20, 0, 0, 0, 5, 2, "R5");
    do_op(0, 0, 0, 0, 0, 0, 0, 0, 4, 9, "R5/R6");
    // R6: idle cycles hold
    do_op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
    do_op(0, 0, 0, 0, 0, 0, 0, 0, 15, 15, "R6");
    // R3 R4: shift the whole band out and beyond, writing operand at the same time
    for (int i = 0; i < 34; i++) do_op(0, 0, 0, 1, 30 + i, (i % 4) == 0, i % 16, 40 + i,
                                       i % 16, (i * 5) % 16, "R3/R4/R7");
    // R9 R10: sweep the selects while idle
    for (int s = 0; s < 16; s++) do_op(0, 0, 0, 0, 0, 0, 0, 0, s, 15 - s, "R9/R10");
    // R2: load of the last row while idle otherwise
    do_op(1, 15, 9, 0, 0, 0, 0, 0, 15, 0, "R2/R9");
    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule